// File: doc/BRIEF.md
# Prefix-Extended Index Register Unit

This block keeps the two 16-bit index registers of a 4-bit-data processor, an 8-bit extension byte, and three flags: carry C, zero Z and the extension flag E. On each valid cycle it takes a decoded operation code, the 8-bit BA pair value and an 8-bit immediate. It can write either byte of an index register, add an 8-bit value or a signed 8-bit value to a register, or compare a register against an immediate.

Writing the extension byte arms E. The immediately following instruction, if it is an immediate low-byte load, a signed add or a compare, then uses the 16-bit value {extension, immediate} in place of its 8-bit immediate. Any other valid instruction does not widen and simply drops E. The register values and the flags are outputs, so the rest of the core can form addresses and branch on the flags.

Top module: `idx_unit`

## Requirements
- R1: After reset, X, Y and the extension byte are 0, and C, Z and E are 0.
- R2: When opValid is 0, no register or flag changes, whatever the code and operands.
- R3: Codes 4'h6 (extension byte from BA) and 4'h7 (extension byte from immediate) load the extension byte and set E to 1. X, Y, C and Z stay unchanged.
- R4: Every other valid code clears E. This includes 4'hE and 4'hF, which stand for instructions outside this block. Only codes 4'h1, 4'h4, 4'h9, 4'hB, 4'hC and 4'hD are widened by E.
- R5: Codes 4'h0/4'h2 write BA into the low/high byte of X, and codes 4'h3/4'h5 do the same for Y. The other byte is kept. Byte loads leave C and Z unchanged.
- R6: Codes 4'h1 (X) and 4'h4 (Y) write the immediate into the low byte when E is 0. When E is 1 they load the whole register with {extension, immediate}.
- R7: Codes 4'h8 (X) and 4'hA (Y) add the zero-extended BA value modulo 2^16. Z is set when the result is zero, and C is unchanged. E never widens these codes.
- R8: Codes 4'h9 (X) and 4'hB (Y) add the sign-extended immediate (-128..127) when E is 0, and {extension, immediate} when E is 1. Z is updated and C is unchanged.
- R9: Codes 4'hC (X) and 4'hD (Y) subtract the zero-extended immediate, or {extension, immediate} when E is 1, and keep the register. C is set on borrow (register below operand) and Z is set when the difference is zero.
- R10: Operations on X never change Y, and operations on Y never change X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | The operation is executed on this edge |
| opCode | input | 4 | Decoded operation code |
| baVal | input | 8 | BA register pair value |
| immVal | input | 8 | Instruction immediate |
| xOut | output | 16 | Index register X |
| yOut | output | 16 | Index register Y |
| cFlag | output | 1 | Carry / borrow flag |
| zFlag | output | 1 | Zero flag |
| eFlag | output | 1 | Extension armed flag |

## Verification
The bench arms E and then issues a non-eligible operation, a foreign code or a BA add. A design that kept E alive too long would then widen the next immediate load, which shows up as a wrong high byte. A signed add of a small positive immediate under E must give a 16-bit sum, so a design that sign-extends instead of using the extension byte comes out with a high byte of zero. Wrap-around adds that hit exactly zero check that Z follows the 16-bit result. A borrow set earlier must survive every add, which catches an add that touches C. Compares near equality check the borrow direction and that the register is left untouched.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  typedef enum logic [3:0] {
    OP_XL_BA   = 4'h0, OP_XL_IMM  = 4'h1, OP_XH_BA   = 4'h2,
    OP_YL_BA   = 4'h3, OP_YL_IMM  = 4'h4, OP_YH_BA   = 4'h5,
    OP_EXT_BA  = 4'h6, OP_EXT_IMM = 4'h7, OP_ADDX_BA = 4'h8,
    OP_ADDX_S8 = 4'h9, OP_ADDY_BA = 4'hA, OP_ADDY_S8 = 4'hB,
    OP_CMPX    = 4'hC, OP_CMPY    = 4'hD, OP_OTHER   = 4'hE,
    OP_OTHER2  = 4'hF
  } idxOp_e;

  typedef enum logic [1:0] {K_NONE, K_LOAD, K_ADD, K_CMP} kind_e;

  typedef struct packed {
    logic  act;     // valid cycle
    kind_e kind;
    logic  selY;    // 1: Y, 0: X
    logic  hiHalf;  // byte load goes to high half
    logic  srcImm;  // operand byte is the immediate
    logic  sgn;     // sign-extend immediate
    logic  wide;    // use {ext, imm}
    logic  wrExt;   // load extension byte
  } strobe_t;
endpackage

// File: rtl/idx_ctrl.sv
module idx_ctrl
  import idx_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       eFlag,
  output strobe_t    stb
);
  logic eligible;

  always_comb begin
    stb      = '0;
    stb.kind = K_NONE;
    eligible = 1'b0;
    stb.act  = opValid;
    case (idxOp_e'(opCode))
      OP_XL_BA:   stb.kind = K_LOAD;
      OP_XH_BA:   begin stb.kind = K_LOAD; stb.hiHalf = 1'b1; end
      OP_XL_IMM:  begin stb.kind = K_LOAD; stb.srcImm = 1'b1; eligible = 1'b1; end
      OP_YL_BA:   begin stb.kind = K_LOAD; stb.selY = 1'b1; end
      OP_YH_BA:   begin stb.kind = K_LOAD; stb.selY = 1'b1; stb.hiHalf = 1'b1; end
      OP_YL_IMM:  begin stb.kind = K_LOAD; stb.selY = 1'b1; stb.srcImm = 1'b1; eligible = 1'b1; end
      OP_EXT_BA:  stb.wrExt = 1'b1;
      OP_EXT_IMM: begin stb.wrExt = 1'b1; stb.srcImm = 1'b1; end
      OP_ADDX_BA: stb.kind = K_ADD;
      OP_ADDY_BA: begin stb.kind = K_ADD; stb.selY = 1'b1; end
      OP_ADDX_S8: begin stb.kind = K_ADD; stb.srcImm = 1'b1; stb.sgn = 1'b1; eligible = 1'b1; end
      OP_ADDY_S8: begin stb.kind = K_ADD; stb.selY = 1'b1; stb.srcImm = 1'b1; stb.sgn = 1'b1; eligible = 1'b1; end
      OP_CMPX:    begin stb.kind = K_CMP; stb.srcImm = 1'b1; eligible = 1'b1; end
      OP_CMPY:    begin stb.kind = K_CMP; stb.selY = 1'b1; stb.srcImm = 1'b1; eligible = 1'b1; end
      default:    stb.kind = K_NONE;
    endcase
    stb.wide = eligible & eFlag;
  end
endmodule

// File: rtl/idx_dpath.sv
module idx_dpath
  import idx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [BYTE_W-1:0]   baVal,
  input  logic [BYTE_W-1:0]   immVal,
  output logic [REG_W-1:0]    xOut,
  output logic [REG_W-1:0]    yOut,
  output logic                cFlag,
  output logic                zFlag,
  output logic                eFlag
);
  logic [REG_W-1:0]  idxReg [2];
  logic [BYTE_W-1:0] extReg;
  logic [REG_W-1:0]  regCur, operand, loadVal, sumVal, newVal;
  logic [REG_W:0]    diffVal;
  logic [BYTE_W-1:0] srcByte;
  logic [REG_W-1:0]  wideImm;

  assign regCur  = stb.selY ? idxReg[1] : idxReg[0];
  assign srcByte = stb.srcImm ? immVal : baVal;
  assign wideImm = {extReg, immVal};

  always_comb begin
    if (stb.wide)
      operand = wideImm;
    else if (stb.srcImm && stb.sgn)
      operand = {{BYTE_W{immVal[BYTE_W-1]}}, immVal};
    else
      operand = {{BYTE_W{1'b0}}, srcByte};

    if (stb.wide)
      loadVal = wideImm;
    else if (stb.hiHalf)
      loadVal = {srcByte, regCur[BYTE_W-1:0]};
    else
      loadVal = {regCur[REG_W-1:BYTE_W], srcByte};

    sumVal  = regCur + operand;
    diffVal = {1'b0, regCur} - {1'b0, operand};
    newVal  = (stb.kind == K_ADD) ? sumVal : loadVal;
  end

  for (genvar g = 0; g < 2; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)
        idxReg[g] <= '0;
      else if (stb.act && (stb.selY == g[0]) &&
               (stb.kind == K_LOAD || stb.kind == K_ADD))
        idxReg[g] <= newVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extReg <= '0;
      eFlag  <= 1'b0;
      cFlag  <= 1'b0;
      zFlag  <= 1'b0;
    end else if (stb.act) begin
      eFlag <= stb.wrExt;
      if (stb.wrExt) extReg <= srcByte;
      if (stb.kind == K_ADD) zFlag <= (sumVal == '0);
      if (stb.kind == K_CMP) begin
        cFlag <= diffVal[REG_W];
        zFlag <= (diffVal[REG_W-1:0] == '0);
      end
    end
  end

  assign xOut = idxReg[0];
  assign yOut = idxReg[1];
endmodule

// File: rtl/idx_unit.sv
module idx_unit
  import idx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [BYTE_W-1:0] baVal,
  input  logic [BYTE_W-1:0] immVal,
  output logic [REG_W-1:0]  xOut,
  output logic [REG_W-1:0]  yOut,
  output logic              cFlag,
  output logic              zFlag,
  output logic              eFlag
);
  strobe_t stb;

  idx_ctrl u_ctrl (
    .opValid(opValid), .opCode(opCode), .eFlag(eFlag), .stb(stb)
  );

  idx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .baVal(baVal), .immVal(immVal),
    .xOut(xOut), .yOut(yOut), .cFlag(cFlag), .zFlag(zFlag), .eFlag(eFlag)
  );
endmodule

// File: rtl/idx_unit_chk.sv
module idx_unit_chk
  import idx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [BYTE_W-1:0] baVal,
  input logic [BYTE_W-1:0] immVal,
  input logic [REG_W-1:0]  xOut,
  input logic [REG_W-1:0]  yOut,
  input logic              cFlag,
  input logic              zFlag,
  input logic              eFlag
);
  logic isExt, isXop, isYop, isAdd, isCmp;
  assign isExt = opValid && (opCode == 4'h6 || opCode == 4'h7);
  assign isXop = opValid && (opCode inside {4'h0, 4'h1, 4'h2, 4'h8, 4'h9, 4'hC});
  assign isYop = opValid && (opCode inside {4'h3, 4'h4, 4'h5, 4'hA, 4'hB, 4'hD});
  assign isAdd = opValid && (opCode inside {4'h8, 4'h9, 4'hA, 4'hB});
  assign isCmp = opValid && (opCode == 4'hC || opCode == 4'hD);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(xOut) && $stable(yOut) && $stable(cFlag) && $stable(zFlag) && $stable(eFlag)); // R2
  AST_EXT_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    isExt |=> eFlag && $stable(xOut) && $stable(yOut)); // R3
  AST_E_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !isExt |=> !eFlag); // R4
  AST_XH_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 4'h2 |=> xOut[BYTE_W-1:0] == $past(xOut[BYTE_W-1:0]) && xOut[REG_W-1:BYTE_W] == $past(baVal)); // R5
  AST_ADD_KEEPS_C: assert property (@(posedge clk) disable iff (!rstN)
    isAdd |=> $stable(cFlag)); // R7
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |=> $stable(xOut) && $stable(yOut)); // R9
  AST_X_SPARES_Y: assert property (@(posedge clk) disable iff (!rstN)
    isXop |=> $stable(yOut)); // R10
  AST_Y_SPARES_X: assert property (@(posedge clk) disable iff (!rstN)
    isYop |=> $stable(xOut)); // R10
endmodule

bind idx_unit idx_unit_chk u_chk (.*);

// File: tb/sim_idx_unit.sv
`timescale 1ns/1ps
module sim_idx_unit;
  logic clk = 1'b0, rstN = 1'b0, opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] baVal = '0, immVal = '0;
  logic [15:0] xOut, yOut;
  logic cFlag, zFlag, eFlag;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idx_unit u0 (.*);

  task automatic op(input logic [3:0] c, input logic [7:0] b, input logic [7:0] i, input logic v = 1'b1);
    @(negedge clk);
    opCode = c; baVal = b; immVal = i; opValid = v;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect5(input string tag, input logic [15:0] x, input logic [15:0] y,
                         input logic c, input logic z, input logic e);
    chk({tag, " X"}, xOut, x);
    chk({tag, " Y"}, yOut, y);
    chk({tag, " C"}, {15'd0, cFlag}, {15'd0, c});
    chk({tag, " Z"}, {15'd0, zFlag}, {15'd0, z});
    chk({tag, " E"}, {15'd0, eFlag}, {15'd0, e});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expect5("R1 reset", 16'h0000, 16'h0000, 0, 0, 0);
  endtask

  task automatic t_cmpBorrow();
    op(4'hC, 8'h00, 8'h01);
    expect5("R9 cmp borrow", 16'h0000, 16'h0000, 1, 0, 0);
  endtask

  task automatic t_bytes();
    op(4'h0, 8'h34, 8'h00); op(4'h2, 8'h12, 8'h00);
    expect5("R5 x bytes", 16'h1234, 16'h0000, 1, 0, 0);
    op(4'h3, 8'h56, 8'h00); op(4'h5, 8'h78, 8'h00);
    expect5("R10 y bytes", 16'h1234, 16'h7856, 1, 0, 0);
  endtask

  task automatic t_idle();
    op(4'h2, 8'hFF, 8'hFF, 1'b0);
    op(4'h7, 8'hFF, 8'hFF, 1'b0);
    expect5("R2 idle", 16'h1234, 16'h7856, 1, 0, 0);
  endtask

  task automatic t_addBa();
    op(4'h8, 8'hF0, 8'h00);
    expect5("R7 add x ba", 16'h1324, 16'h7856, 1, 0, 0);
    op(4'h3, 8'hFF, 8'h00); op(4'h5, 8'hFF, 8'h00); op(4'hA, 8'h01, 8'h00);
    expect5("R7 add y wrap", 16'h1324, 16'h0000, 1, 1, 0);
  endtask

  task automatic t_addS8();
    op(4'h9, 8'h00, 8'hFC);
    expect5("R8 add x -4", 16'h1320, 16'h0000, 1, 0, 0);
    op(4'hB, 8'h00, 8'h05);
    expect5("R8 add y +5", 16'h1320, 16'h0005, 1, 0, 0);
  endtask

  task automatic t_immLoad();
    op(4'h1, 8'h00, 8'hAB);
    expect5("R6 xl imm narrow", 16'h13AB, 16'h0005, 1, 0, 0);
    op(4'h7, 8'h00, 8'h5A);
    expect5("R3 ext imm arms", 16'h13AB, 16'h0005, 1, 0, 1);
    op(4'h1, 8'h00, 8'h66);
    expect5("R6 xl imm wide", 16'h5A66, 16'h0005, 1, 0, 0);
  endtask

  task automatic t_wideAdd();
    op(4'h6, 8'h80, 8'h00);
    expect5("R3 ext ba arms", 16'h5A66, 16'h0005, 1, 0, 1);
    op(4'hB, 8'h00, 8'h10);
    expect5("R8 add y wide", 16'h5A66, 16'h8015, 1, 0, 0);
  endtask

  task automatic t_clearE();
    op(4'h7, 8'h00, 8'h22); op(4'hE, 8'h00, 8'h00);
    expect5("R4 foreign clears", 16'h5A66, 16'h8015, 1, 0, 0);
    op(4'h4, 8'h00, 8'h33);
    expect5("R4 yl after clear", 16'h5A66, 16'h8033, 1, 0, 0);
    op(4'h7, 8'h00, 8'h11); op(4'h0, 8'h00, 8'h00);
    expect5("R4 xl ba not wide", 16'h5A00, 16'h8033, 1, 0, 0);
    op(4'h1, 8'h00, 8'h77);
    expect5("R4 xl imm narrow", 16'h5A77, 16'h8033, 1, 0, 0);
    op(4'h7, 8'h00, 8'hFF); op(4'hF, 8'h00, 8'h00);
    chk("R4 code F clears E", {15'd0, eFlag}, 16'h0000);
  endtask

  task automatic t_cmp();
    op(4'h7, 8'h00, 8'h5A); op(4'hC, 8'h00, 8'h77);
    expect5("R9 cmp x wide equal", 16'h5A77, 16'h8033, 0, 1, 0);
    op(4'hC, 8'h00, 8'h78);
    expect5("R9 cmp x narrow", 16'h5A77, 16'h8033, 0, 0, 0);
    op(4'h7, 8'h00, 8'h90); op(4'hD, 8'h00, 8'h00);
    expect5("R9 cmp y wide borrow", 16'h5A77, 16'h8033, 1, 0, 0);
  endtask

  task automatic t_wideWrap();
    op(4'h7, 8'h00, 8'hA5); op(4'h9, 8'h00, 8'h89);
    expect5("R8 add x wide wrap", 16'h0000, 16'h8033, 1, 1, 0);
    op(4'h7, 8'h00, 8'hFF); op(4'h8, 8'h01, 8'h00);
    expect5("R7 add ba ignores E", 16'h0001, 16'h8033, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_cmpBorrow();
    t_bytes();
    t_idle();
    t_addBa();
    t_addS8();
    t_immLoad();
    t_wideAdd();
    t_clearE();
    t_cmp();
    t_wideWrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule